// File: doc/BRIEF.md
# Log-Domain Tile Quantizer

This block compresses one tile of signed 16-bit floating-point samples (sign bit, 8-bit biased exponent, 7-bit fraction) into short codes whose magnitude levels are spaced evenly on a base-2 logarithmic scale. The tile is first taken in over a valid/ready input stream and kept in a local store. While it loads, the block tracks the smallest and largest nonzero log magnitude. It then sets up a grid of levels between those two points. Each element is encoded as its original sign bit plus a level index. The index picks whichever of the two nearest levels is closer in ordinary linear value, not in log value.

The log of a magnitude is a fixed-point number. The integer part is the biased exponent and the fractional part is the raw fraction field, which is the piecewise-linear estimate of log2(1+f). So the log value of an element is simply its 15 magnitude bits read as an unsigned number with 7 fraction bits. The linear value belonging to a log value L is (1 + L[6:0]/128) * 2^(L[14:7]). Every level and every midpoint comparison uses this pair of mappings. The codes then leave on a valid/ready output stream in input order. Each output beat carries the tile's metadata: the clamped minimum log value and the log step. A downstream decoder needs both to rebuild approximate samples.

Control is a five-state machine. LOAD accepts samples and goes to PREP after the last one. PREP registers the metadata and goes to KICK. KICK starts the level search for the current element and goes to WAIT. WAIT holds until the search reports done, then goes to SEND. SEND presents one code. On an accepted beat, SEND goes back to KICK for the next element, or to LOAD after the last element.

Top module: `lq_tile_quant`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: Exactly TILE (128) samples are accepted per tile. in_ready stays 0 from the last accepted sample until the last code of that tile is accepted, and it is 1 again in the next cycle.
- R3: out_min equals the smallest nonzero magnitude field (bits 14:0) of the tile, raised to max − 4096 when it lies more than 4096 below the largest magnitude field max. 4096 is 32 octaves at 7 fraction bits.
- R4: out_step equals floor((max − out_min) * 256 / 126), which is the level spacing with 8 extra fraction bits.
- R5: Bit 7 of every code equals bit 15 of its input sample.
- R6: A sample whose magnitude field is zero gets magnitude code 0 with its sign kept, and it takes no part in the min/max search.
- R7: Magnitude code k (1..127) stands for log value out_min + floor((k−1)*out_step/256). The tile's minimum element gets code 1 and the tile's maximum element gets code 127.
- R8: For a nonzero magnitude with log value L ≥ out_min, let k be the largest code whose level is ≤ L. If k < 127, the result is k+1 when 2·lin(L) ≥ lin(level k) + lin(level k+1), and k otherwise. Ties therefore go upward.
- R9: A nonzero sample whose log value is below out_min, because of clamping, gets magnitude code 1.
- R10: When all nonzero magnitudes in a tile are equal, out_step is 0 and every nonzero element gets magnitude code 127.
- R11: Codes leave in input order. out_last is 1 only on the 128th code. While out_valid is 1 and out_ready is 0, the code and out_last hold steady.
- R12: A tile with no nonzero element reports out_min 0 and out_step 0, and every code has magnitude 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts a sample |
| in_data | input | 16 | Sample: sign, exponent, fraction |
| out_valid | output | 1 | Output code valid |
| out_ready | input | 1 | Consumer accepts the code |
| out_code | output | 8 | Sign bit plus 7-bit level index |
| out_min | output | 15 | Tile minimum log value (clamped) |
| out_step | output | 16 | Log step with 8 fraction bits |
| out_last | output | 1 | Marks the last code of the tile |

## Verification
The assertions check several properties on every cycle. The output code and the last flag must hold during a stall. The input must reopen right after the final code is accepted. The code's sign must match the stored sample, and a zero magnitude must produce a zero index. A finished search on a nonzero sample must never yield index 0. A flat tile must always land on the top index. The range tracker's minimum must never pass its maximum. Only the bench scenarios can show the correctness of the numbers themselves. These are the clamped minimum, the step value, the nearest-level choice in the linear domain against an independent scan of all 127 levels, and the handling of clamped, flat and all-zero tiles.

// File: rtl/lq_pkg.sv
package lq_pkg;
    typedef enum logic [2:0] {
        ST_LOAD,
        ST_PREP,
        ST_KICK,
        ST_WAIT,
        ST_SEND
    } lq_state_e;
endpackage

// File: rtl/lq_tile_store.sv
module lq_tile_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lq_range.sv
module lq_range #(
    parameter int MAG_W   = 15,
    parameter int FRAC_W  = 7,
    parameter int OCTAVES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             upd,
    input  logic [MAG_W-1:0] mag,
    output logic [MAG_W-1:0] lo,
    output logic [MAG_W-1:0] span
);
    localparam int EW = MAG_W + 1;
    localparam logic [EW-1:0] LIM = EW'(OCTAVES << FRAC_W);

    logic [MAG_W-1:0] mn, mx;
    logic             seen;
    logic [EW-1:0]    gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mn   <= '1;
            mx   <= '0;
            seen <= 1'b0;
        end else if (clear) begin
            mn   <= '1;
            mx   <= '0;
            seen <= 1'b0;
        end else if (upd) begin
            if (mag < mn) mn <= mag;
            if (mag > mx) mx <= mag;
            seen <= 1'b1;
        end
    end

    always_comb begin
        gap = EW'(mx) - EW'(mn);
        if (!seen)           lo = '0;
        else if (gap > LIM)  lo = MAG_W'(EW'(mx) - LIM);
        else                 lo = mn;
        span = seen ? (mx - lo) : '0;
    end

    // R3: the tracked minimum never passes the tracked maximum
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (mn <= mx));
endmodule

// File: rtl/lq_level_pick.sv
module lq_level_pick #(
    parameter int MAG_W     = 15,
    parameter int FRAC_W    = 7,
    parameter int IDX_W     = 7,
    parameter int STEP_W    = 16,
    parameter int STEP_FRAC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MAG_W-1:0]  mag,
    input  logic [MAG_W-1:0]  lo,
    input  logic [STEP_W-1:0] step,
    output logic              done,
    output logic [IDX_W-1:0]  code
);
    localparam int TOPK = (1 << IDX_W) - 1;
    localparam int LW   = MAG_W + 1;
    localparam int PW   = STEP_W + IDX_W;
    localparam int CW   = $clog2(IDX_W + 1);
    localparam int EXW  = LW - FRAC_W;
    localparam int MW   = FRAC_W + 4;

    function automatic logic [LW-1:0] lvl(input logic [IDX_W-1:0] j,
                                          input logic [MAG_W-1:0] base,
                                          input logic [STEP_W-1:0] st);
        logic [PW-1:0] p;
        p = PW'(j) * PW'(st);
        return LW'(base) + LW'(p >> STEP_FRAC);
    endfunction

    // mantissa of v scaled to the exponent e0 (v lies at most one octave above)
    function automatic logic [MW-1:0] rel(input logic [LW-1:0] v,
                                          input logic [EXW-1:0] e0);
        logic [MW-1:0] m;
        m = MW'({1'b1, v[FRAC_W-1:0]});
        return (v[LW-1:FRAC_W] != e0) ? (m << 1) : m;
    endfunction

    logic             srch, dec;
    logic [CW-1:0]    bitp;
    logic [IDX_W-1:0] acc, trial, pick_n;
    logic [MAG_W-1:0] lreg;
    logic             keep_trial, up;
    logic [LW-1:0]    la, lb;

    always_comb begin
        trial      = acc | (IDX_W'(1) << bitp);
        keep_trial = (trial <= IDX_W'(TOPK - 1)) && (lvl(trial, lo, step) <= LW'(lreg));
        la         = lvl(acc, lo, step);
        lb         = lvl(acc + IDX_W'(1), lo, step);
        up         = (rel(LW'(lreg), la[LW-1:FRAC_W]) << 1)
                     >= (rel(la, la[LW-1:FRAC_W]) + rel(lb, la[LW-1:FRAC_W]));
        if (lreg == '0)                  pick_n = '0;
        else if (lreg < lo)              pick_n = IDX_W'(1);
        else if (acc == IDX_W'(TOPK-1))  pick_n = IDX_W'(TOPK);
        else if (up)                     pick_n = acc + IDX_W'(2);
        else                             pick_n = acc + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srch <= 1'b0;
            dec  <= 1'b0;
            done <= 1'b0;
            bitp <= '0;
            acc  <= '0;
            lreg <= '0;
            code <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                lreg <= mag;
                acc  <= '0;
                bitp <= CW'(IDX_W - 1);
                srch <= 1'b1;
                dec  <= 1'b0;
            end else if (srch) begin
                if (keep_trial) acc <= trial;
                if (bitp == '0) begin
                    srch <= 1'b0;
                    dec  <= 1'b1;
                end else begin
                    bitp <= bitp - CW'(1);
                end
            end else if (dec) begin
                code <= pick_n;
                done <= 1'b1;
                dec  <= 1'b0;
            end
        end
    end

    // R7: a nonzero sample never ends at magnitude index 0
    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lreg != '0) |-> (code != '0));

    // R10: with a zero step every in-range nonzero sample lands on the top index
    p_flat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && step == '0 && lreg != '0 && lreg >= lo) |-> (code == IDX_W'(TOPK)));
endmodule

// File: rtl/lq_tile_quant.sv
module lq_tile_quant
    import lq_pkg::*;
#(
    parameter int TILE      = 128,
    parameter int DW        = 16,
    parameter int MAG_W     = 15,
    parameter int FRAC_W    = 7,
    parameter int CODE_W    = 8,
    parameter int OCTAVES   = 32,
    parameter int STEP_FRAC = 8,
    parameter int STEP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] out_code,
    output logic [MAG_W-1:0]  out_min,
    output logic [STEP_W-1:0] out_step,
    output logic              out_last
);
    localparam int AW    = $clog2(TILE);
    localparam int IDX_W = CODE_W - 1;
    localparam int DIV   = (1 << IDX_W) - 2;
    localparam logic [AW-1:0] LAST = AW'(TILE - 1);

    lq_state_e        st, st_n;
    logic [AW-1:0]    ptr;
    logic [DW-1:0]    rd_data;
    logic [MAG_W-1:0] rng_lo, rng_span, lo_r;
    logic [STEP_W-1:0] step_r;
    logic [31:0]      step_q;
    logic             pick_start, pick_done;
    logic [IDX_W-1:0] pick_code;
    logic             in_fire, out_fire, at_last;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign at_last  = (ptr == LAST);
    assign step_q   = (32'(rng_span) << STEP_FRAC) / 32'(DIV);

    lq_tile_store #(.DEPTH(TILE), .DW(DW)) u_store (
        .clk   (clk),
        .we    (in_fire),
        .waddr (ptr),
        .wdata (in_data),
        .raddr (ptr),
        .rdata (rd_data)
    );

    lq_range #(.MAG_W(MAG_W), .FRAC_W(FRAC_W), .OCTAVES(OCTAVES)) u_range (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (out_fire && at_last),
        .upd   (in_fire && (in_data[MAG_W-1:0] != '0)),
        .mag   (in_data[MAG_W-1:0]),
        .lo    (rng_lo),
        .span  (rng_span)
    );

    lq_level_pick #(
        .MAG_W(MAG_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W),
        .STEP_W(STEP_W), .STEP_FRAC(STEP_FRAC)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pick_start),
        .mag   (rd_data[MAG_W-1:0]),
        .lo    (lo_r),
        .step  (step_r),
        .done  (pick_done),
        .code  (pick_code)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOAD;
        else        st <= st_n;
    end

    // transitions
    always_comb begin
        st_n = st;
        unique case (st)
            ST_LOAD: if (in_fire && at_last) st_n = ST_PREP;
            ST_PREP: st_n = ST_KICK;
            ST_KICK: st_n = ST_WAIT;
            ST_WAIT: if (pick_done) st_n = ST_SEND;
            ST_SEND: if (out_fire) st_n = at_last ? ST_LOAD : ST_KICK;
            default: st_n = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        pick_start = 1'b0;
        unique case (st)
            ST_LOAD: in_ready   = 1'b1;
            ST_KICK: pick_start = 1'b1;
            ST_SEND: out_valid  = 1'b1;
            default: ;
        endcase
        out_code = {rd_data[DW-1], pick_code};
        out_min  = lo_r;
        out_step = step_r;
        out_last = out_valid && at_last;
    end

    // pointer and metadata
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            lo_r   <= '0;
            step_r <= '0;
        end else begin
            if (in_fire || out_fire) ptr <= at_last ? '0 : ptr + AW'(1);
            if (st == ST_PREP) begin
                lo_r   <= rng_lo;
                step_r <= STEP_W'(step_q);
            end
        end
    end

    // R11: a stalled beat holds its code and last flag
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_last)));

    // R2: the input reopens right after the final code of a tile
    p_reopen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_last) |=> in_ready);

    // R5: the code's top bit follows the stored sample's sign
    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code[CODE_W-1] == rd_data[DW-1]));

    // R6: a zero magnitude gives a zero index
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rd_data[MAG_W-1:0] == '0) |-> (out_code[CODE_W-2:0] == '0));
endmodule

// File: tb/lq_tile_quant_bench.sv
module lq_tile_quant_bench;
    localparam int TILE = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_code;
    logic [14:0] out_min;
    logic [15:0] out_step;
    logic        out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    logic [15:0] tile [TILE];
    int exp_lo, exp_step;

    always #10 clk = ~clk;

    lq_tile_quant u_lq_tile_quant (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
        .out_min(out_min), .out_step(out_step), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected metadata from the requirement text (R3, R4, R12)
    task automatic calc_meta();
        int mn = 32768;
        int mx = -1;
        for (int i = 0; i < TILE; i++) begin
            int m = int'(tile[i][14:0]);
            if (m != 0) begin
                if (m < mn) mn = m;
                if (m > mx) mx = m;
            end
        end
        if (mx < 0) begin
            exp_lo = 0;
            exp_step = 0;
        end else begin
            exp_lo = (mx - mn > 4096) ? mx - 4096 : mn;
            exp_step = ((mx - exp_lo) * 256) / 126;
        end
    endtask

    function automatic int level(input int k);
        return exp_lo + (((k - 1) * exp_step) >> 8);
    endfunction

    function automatic real lin_rel(input int v, input int e0);
        real r = 128.0 + real'(v % 128);
        for (int e = e0; e < v / 128; e++) r = r * 2.0;
        return r;
    endfunction

    // exhaustive scan of all levels (R7, R8, R9)
    function automatic int model_mag(input int m);
        int k = 1;
        int a, b, e0;
        if (m == 0) return 0;
        if (m < exp_lo) return 1;
        for (int kk = 2; kk <= 127; kk++) if (level(kk) <= m) k = kk;
        if (k == 127) return 127;
        a = level(k);
        b = level(k + 1);
        e0 = a / 128;
        if (2.0 * lin_rel(m, e0) >= lin_rel(a, e0) + lin_rel(b, e0)) return k + 1;
        return k;
    endfunction

    task automatic load_tile();
        for (int i = 0; i < TILE; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b1, "R2", "in_ready during load", int'(in_ready), 1);
            in_valid = 1'b1;
            in_data = tile[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2", "in_ready after last sample", int'(in_ready), 0);
    endtask

    task automatic drain_tile(input string name, input int stall_at);
        for (int i = 0; i < TILE; i++) begin
            int m = int'(tile[i][14:0]);
            int em;
            string tag;
            do @(negedge clk); while (!out_valid);
            if (i == stall_at) begin
                logic [7:0] held = out_code;
                repeat (3) @(negedge clk);
                chk(out_valid && out_code == held, "R11", "stalled beat", int'(out_code), int'(held));
            end
            if (i == 0) begin
                chk(int'(out_min) == exp_lo, "R3", "out_min", int'(out_min), exp_lo);
                chk(int'(out_step) == exp_step, "R4", "out_step", int'(out_step), exp_step);
            end
            if (i == 7) chk(in_ready == 1'b0, "R2", "in_ready while sending", int'(in_ready), 0);
            em = model_mag(m);
            if (m == 0) tag = "R6";
            else if (m < exp_lo) tag = "R9";
            else tag = "R8";
            chk(out_code[7] == tile[i][15], "R5", "sign bit", int'(out_code[7]), int'(tile[i][15]));
            chk(int'(out_code[6:0]) == em, tag, name, int'(out_code[6:0]), em);
            chk(out_last == (i == TILE - 1), "R11", "out_last", int'(out_last), int'(i == TILE - 1));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk(in_ready == 1'b1, "R2", "in_ready after tile", int'(in_ready), 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready at reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid at reset", int'(out_valid), 0);
    endtask

    task automatic test_ramp();
        for (int i = 0; i < TILE; i++) begin
            tile[i] = 16'h3C00 + 16'(i * 29);
            tile[i][15] = (i % 3 == 0);
        end
        tile[5] = 16'h8000;
        calc_meta();
        load_tile();
        drain_tile("ramp code", 3);
        // R7: endpoints of the ramp, from the same expected table
        chk(model_mag(int'(tile[0][14:0])) == 1, "R7", "min element code", model_mag(int'(tile[0][14:0])), 1);
        chk(model_mag(int'(tile[127][14:0])) == 127, "R7", "max element code", model_mag(int'(tile[127][14:0])), 127);
    endtask

    task automatic test_clamp();
        for (int i = 0; i < TILE; i++) begin
            tile[i] = 16'h4000 + 16'(i * 16);
            tile[i][15] = i[0];
        end
        tile[0] = 16'h0100;
        tile[1] = 16'h8180;
        calc_meta();
        chk(exp_lo == 16'h47F0 - 4096, "R3", "clamp premise", exp_lo, 16'h47F0 - 4096);
        load_tile();
        drain_tile("clamped code", -1);
    endtask

    task automatic test_flat();
        for (int i = 0; i < TILE; i++) begin
            if (i % 16 == 0) tile[i] = 16'h8000;
            else if (i % 8 == 0) tile[i] = 16'h0000;
            else tile[i] = 16'hBF80;
        end
        calc_meta();
        load_tile();
        drain_tile("flat code R10", 10);
    endtask

    task automatic test_zero();
        for (int i = 0; i < TILE; i++) tile[i] = i[0] ? 16'h8000 : 16'h0000;
        calc_meta();
        load_tile();
        drain_tile("all-zero code R12", -1);
    endtask

    task automatic test_scatter();
        for (int i = 0; i < TILE; i++) begin
            tile[i] = 16'h4100 + 16'((i * 97) % 1500);
            tile[i][15] = i[1];
        end
        calc_meta();
        load_tile();
        drain_tile("scatter code", 60);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                finished = 1;
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_ramp();
        test_clamp();
        test_flat();
        test_zero();
        test_scatter();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule